// File: doc/BRIEF.md
# I2C Combined-Transaction Sequencer

This block runs complete register-style I2C transactions on top of a byte-level I2C master engine. One request names a 7-bit target, a register address of zero to four bytes, a direction and a byte count. The sequencer then drives the engine through the whole exchange: the address phase, the register bytes most significant first, and then either the outgoing data or a repeated START followed by the incoming bytes. It finishes with a STOP and a one-hot status.

Outgoing data comes from a valid/ready byte stream. Incoming data leaves through another valid/ready byte stream. The engine is driven one operation at a time through a pulse-and-done interface. Every wait, whether on the bus going idle or on one engine operation, is guarded by a timeout measured in clock cycles and derived from the clock frequency. A probe request checks whether a target is present. A build-time mask can fold high register-address bits into the low bits of the target address, for memories that hide extra address bits there.

Top module: `i2c_txn_seq`

## Requirements
- R1: Engine operation codes on `eng_op` are 0 = START then send byte, 1 = START then send byte and switch to receive, 2 = send byte, 3 = receive byte, 4 = STOP. The first operation is code 0 carrying `{chip,1'b0}` when the request is a write or has a register address. Otherwise it is code 1 carrying `{chip,1'b1}`.
- R2: `req_alen` register-address bytes are sent with code 2, most significant byte first, taken from the low `8*req_alen` bits of `req_addr`. A length of 0 sends no register byte.
- R3: A read that has a register address issues a repeated START (code 1) carrying `{chip,1'b1}` after the last register byte and before the first receive.
- R4: Each receive (code 3) drives `eng_ack`=1 except on the final byte, which gets `eng_ack`=0. A NACK reported on a receive ends the read with status OK. Received bytes leave on `rd_data` in order, with `rd_valid` held and `rd_data` stable until `rd_ready`.
- R5: A NACK on the address, repeated START, register or write byte stops the transfer. No further data operation follows, and the status is NACK.
- R6: A request with `req_len`=0 or `req_alen`>4 (probe excluded) is rejected. `done` rises in the cycle after acceptance with status BAD, and no engine operation is issued.
- R7: After acceptance the sequencer waits for `bus_busy` low. If the bus stays busy for the timeout (TIMEOUT_US microseconds of clock cycles), it ends with status TIMEOUT and issues no STOP.
- R8: If an engine operation gets no `eng_done` within the timeout, the transaction ends with status TIMEOUT after a STOP.
- R9: Every transaction that got past the bus wait ends with a STOP (code 4), and `done` follows in the next cycle.
- R10: The target address actually sent is `chip | ((req_addr >> 8*req_alen) & OVF_MASK)`.
- R11: A probe sends `{chip,1'b1}` with code 1, then one receive with `eng_ack`=0. It pushes nothing onto `rd_data` and reports OK if the address was acknowledged, NACK if not.
- R12: `status` is one-hot: bit0 OK, bit1 NACK, bit2 TIMEOUT, bit3 BAD. `done` is a one-cycle pulse. `status` holds until the next accepted request and is 0 after reset.
- R13: Each write byte is taken from `wr_data` in a cycle where `wr_valid` and `wr_ready` are both high, and is sent with code 2 in that same cycle. `wr_ready` is never high without `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_chip | input | 7 | 7-bit target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_probe | input | 1 | Probe request (ignores read, length, address) |
| req_alen | input | AL_W | Register-address byte count |
| req_addr | input | ADDR_W | Register address |
| req_len | input | LEN_W | Data byte count |
| bus_busy | input | 1 | Bus currently owned |
| eng_go | output | 1 | Engine operation strobe |
| eng_op | output | 3 | Engine operation code |
| eng_byte | output | 8 | Byte to send |
| eng_ack | output | 1 | ACK to drive after a received byte |
| eng_done | input | 1 | Engine operation finished |
| eng_nack | input | 1 | NACK seen on the finished operation |
| eng_rdata | input | 8 | Byte received by the engine |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction finished (pulse) |
| status | output | 4 | One-hot result |

## Verification
The bench checks the order of operations for each request shape: write with and without a register address, read with and without one, a four-byte address, and a probe. A design that inserted the repeated START unconditionally, or sent register bytes least significant first, would log a different operation list. NACKs are injected on the address byte and in the middle of a write, and the bench expects a STOP right after each. It also checks that the closing NACK of a read is reported as success, so a design that treated that NACK as an error would show the NACK status. Hung engine operations and a stuck bus are checked for a TIMEOUT status with and without a STOP, rejected requests for zero engine activity, and the overflow mask for the altered first byte.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    OP_START_TX = 3'd0,
    OP_START_RX = 3'd1,
    OP_SEND     = 3'd2,
    OP_RECV     = 3'd3,
    OP_STOP     = 3'd4
  } eng_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_BUS, S_ISSUE, S_WAIT, S_FEED, S_DELIVER, S_STOP, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_ADDR, PH_REG, PH_RS, PH_WR, PH_RD
  } seq_phase_e;

  localparam logic [3:0] ST_OK   = 4'b0001;
  localparam logic [3:0] ST_NACK = 4'b0010;
  localparam logic [3:0] ST_TOUT = 4'b0100;
  localparam logic [3:0] ST_BAD  = 4'b1000;

  // Register byte number idx (0 = first on the wire) of an alen-byte address.
  function automatic logic [7:0] reg_byte(input logic [63:0] a,
                                          input logic [7:0] alen,
                                          input logic [7:0] idx);
    return 8'(a >> {(alen - idx - 8'd1), 3'b000});
  endfunction

  // Target address with the spare high address bits folded in.
  function automatic logic [6:0] fold_chip(input logic [6:0] chip,
                                           input logic [63:0] a,
                                           input logic [7:0] alen,
                                           input logic [6:0] mask);
    return chip | (7'(a >> {alen, 3'b000}) & mask);
  endfunction

endpackage

// File: rtl/i2cseq_reqlatch.sv
module i2cseq_reqlatch
  import i2cseq_pkg::*;
#(
  parameter int         AL_W       = 3,
  parameter int         ADDR_W     = 32,
  parameter int         LEN_W      = 16,
  parameter int         ADDR_BYTES = 4,
  parameter logic [6:0] OVF_MASK   = 7'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [6:0]        req_chip,
  input  logic              req_read,
  input  logic              req_probe,
  input  logic [AL_W-1:0]   req_alen,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_bad,
  output logic [6:0]        q_chip,
  output logic              q_rd,
  output logic              q_probe,
  output logic [AL_W-1:0]   q_alen,
  output logic [ADDR_W-1:0] q_addr,
  output logic [LEN_W-1:0]  q_len
);

  logic [6:0] chip_folded;

  assign req_bad = !req_probe &&
                   ((req_len == '0) || (req_alen > AL_W'(ADDR_BYTES)));

  assign chip_folded = fold_chip(req_chip, 64'(req_addr), 8'(req_alen), OVF_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_chip  <= '0;
      q_rd    <= 1'b0;
      q_probe <= 1'b0;
      q_alen  <= '0;
      q_addr  <= '0;
      q_len   <= '0;
    end else if (load) begin
      q_probe <= req_probe;
      q_addr  <= req_addr;
      if (req_probe) begin
        q_chip <= req_chip;
        q_rd   <= 1'b1;
        q_alen <= '0;
        q_len  <= LEN_W'(1);
      end else begin
        q_chip <= chip_folded;
        q_rd   <= req_read;
        q_alen <= req_alen;
        q_len  <= req_len;
      end
    end
  end

endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (!expired)  cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int AL_W   = 3,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_bad,
  output logic              req_ready,
  output logic              accept,
  input  logic [6:0]        q_chip,
  input  logic              q_rd,
  input  logic              q_probe,
  input  logic [AL_W-1:0]   q_alen,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [LEN_W-1:0]  q_len,
  input  logic              bus_busy,
  output logic              eng_go,
  output logic [2:0]        eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_ack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              tmr_run,
  input  logic              tmr_exp,
  output logic              done,
  output logic [3:0]        status
);

  seq_state_e       state;
  seq_phase_e       phase;
  logic [AL_W-1:0]  idx;
  logic [LEN_W-1:0] cnt;
  logic             rd_last;

  logic first_tx, cnt_last, reg_last;

  assign first_tx  = !q_rd || (q_alen != '0);
  assign cnt_last  = (cnt == q_len - LEN_W'(1));
  assign reg_last  = (idx == q_alen - AL_W'(1));
  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_valid  = (state == S_DELIVER);
  assign tmr_run   = (state == S_BUS) || (state == S_WAIT);
  assign done      = (state == S_DONE);

  always_comb begin
    eng_go   = 1'b0;
    eng_op   = OP_STOP;
    eng_byte = 8'h00;
    eng_ack  = 1'b0;
    wr_ready = 1'b0;
    case (state)
      S_ISSUE: begin
        eng_go = 1'b1;
        case (phase)
          PH_ADDR: begin
            eng_op   = first_tx ? OP_START_TX : OP_START_RX;
            eng_byte = {q_chip, !first_tx};
          end
          PH_REG: begin
            eng_op   = OP_SEND;
            eng_byte = reg_byte(64'(q_addr), 8'(q_alen), 8'(idx));
          end
          PH_RS: begin
            eng_op   = OP_START_RX;
            eng_byte = {q_chip, 1'b1};
          end
          default: begin
            eng_op  = OP_RECV;
            eng_ack = !cnt_last;
          end
        endcase
      end
      S_FEED: begin
        if (wr_valid) begin
          wr_ready = 1'b1;
          eng_go   = 1'b1;
          eng_op   = OP_SEND;
          eng_byte = wr_data;
        end
      end
      S_STOP: begin
        eng_go = 1'b1;
        eng_op = OP_STOP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= PH_ADDR;
      idx     <= '0;
      cnt     <= '0;
      rd_last <= 1'b0;
      rd_data <= 8'h00;
      status  <= 4'b0000;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (req_bad) begin
              status <= ST_BAD;
              state  <= S_DONE;
            end else begin
              status <= 4'b0000;
              state  <= S_BUS;
            end
          end
        end
        S_BUS: begin
          if (!bus_busy) begin
            phase <= PH_ADDR;
            state <= S_ISSUE;
          end else if (tmr_exp) begin
            status <= ST_TOUT;
            state  <= S_DONE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_FEED:  if (wr_valid) state <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            if (phase == PH_RD) begin
              rd_data <= eng_rdata;
              if (q_probe) begin
                status <= ST_OK;
                state  <= S_STOP;
              end else begin
                rd_last <= cnt_last || eng_nack;
                state   <= S_DELIVER;
              end
            end else if (eng_nack) begin
              status <= ST_NACK;
              state  <= S_STOP;
            end else begin
              case (phase)
                PH_ADDR: begin
                  cnt <= '0;
                  idx <= '0;
                  if (q_alen != '0) begin
                    phase <= PH_REG;
                    state <= S_ISSUE;
                  end else if (q_rd) begin
                    phase <= PH_RD;
                    state <= S_ISSUE;
                  end else begin
                    phase <= PH_WR;
                    state <= S_FEED;
                  end
                end
                PH_REG: begin
                  idx <= idx + AL_W'(1);
                  cnt <= '0;
                  if (!reg_last)  state <= S_ISSUE;
                  else if (q_rd) begin
                    phase <= PH_RS;
                    state <= S_ISSUE;
                  end else begin
                    phase <= PH_WR;
                    state <= S_FEED;
                  end
                end
                PH_RS: begin
                  phase <= PH_RD;
                  cnt   <= '0;
                  state <= S_ISSUE;
                end
                default: begin
                  if (cnt_last) begin
                    status <= ST_OK;
                    state  <= S_STOP;
                  end else begin
                    cnt   <= cnt + LEN_W'(1);
                    state <= S_FEED;
                  end
                end
              endcase
            end
          end else if (tmr_exp) begin
            status <= ST_TOUT;
            state  <= S_STOP;
          end
        end
        S_DELIVER: begin
          if (rd_ready) begin
            if (rd_last) begin
              status <= ST_OK;
              state  <= S_STOP;
            end else begin
              cnt   <= cnt + LEN_W'(1);
              state <= S_ISSUE;
            end
          end
        end
        S_STOP:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2cseq_pkg::*;
#(
  parameter int         ADDR_BYTES  = 4,
  parameter int         LEN_W       = 16,
  parameter int         CLK_FREQ_HZ = 100_000_000,
  parameter int         TIMEOUT_US  = 1_000_000,
  parameter logic [6:0] OVF_MASK    = 7'h00,
  localparam int        AL_W        = $clog2(ADDR_BYTES + 1),
  localparam int        ADDR_W      = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [6:0]        req_chip,
  input  logic              req_read,
  input  logic              req_probe,
  input  logic [AL_W-1:0]   req_alen,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              bus_busy,
  output logic              eng_go,
  output logic [2:0]        eng_op,
  output logic [7:0]        eng_byte,
  output logic              eng_ack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [3:0]        status
);

  localparam int TIMEOUT_CYC = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

  // Named internal events shared between the pieces.
  logic              ev_accept;
  logic              ev_bad;
  logic              ev_wait_run;
  logic              ev_expired;
  logic [6:0]        q_chip;
  logic              q_rd;
  logic              q_probe;
  logic [AL_W-1:0]   q_alen;
  logic [ADDR_W-1:0] q_addr;
  logic [LEN_W-1:0]  q_len;

  i2cseq_reqlatch #(
    .AL_W(AL_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .ADDR_BYTES(ADDR_BYTES), .OVF_MASK(OVF_MASK)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .load(ev_accept),
    .req_chip(req_chip), .req_read(req_read), .req_probe(req_probe),
    .req_alen(req_alen), .req_addr(req_addr), .req_len(req_len),
    .req_bad(ev_bad),
    .q_chip(q_chip), .q_rd(q_rd), .q_probe(q_probe),
    .q_alen(q_alen), .q_addr(q_addr), .q_len(q_len)
  );

  i2cseq_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(ev_wait_run), .expired(ev_expired)
  );

  i2cseq_ctrl #(.AL_W(AL_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bad(ev_bad), .req_ready(req_ready),
    .accept(ev_accept),
    .q_chip(q_chip), .q_rd(q_rd), .q_probe(q_probe),
    .q_alen(q_alen), .q_addr(q_addr), .q_len(q_len),
    .bus_busy(bus_busy),
    .eng_go(eng_go), .eng_op(eng_op), .eng_byte(eng_byte), .eng_ack(eng_ack),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tmr_run(ev_wait_run), .tmr_exp(ev_expired),
    .done(done), .status(status)
  );

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
  parameter int AL_W   = 3,
  parameter int LEN_W  = 16,
  parameter int MAX_AB = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_probe,
  input logic [AL_W-1:0]  req_alen,
  input logic [LEN_W-1:0] req_len,
  input logic             eng_go,
  input logic [2:0]       eng_op,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             done,
  input logic [3:0]       status
);

  assert_bad_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_probe &&
     ((req_len == '0) || (req_alen > AL_W'(MAX_AB))))
    |=> (done && status == 4'b1000));

  assert_status_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(status) == 1));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stop_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_op == 3'd4) |=> done);

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);

  assert_wr_handshake_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_valid);

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_go);

endmodule

bind i2c_txn_seq i2cseq_chk #(.AL_W(AL_W), .LEN_W(LEN_W), .MAX_AB(ADDR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_probe(req_probe), .req_alen(req_alen), .req_len(req_len),
  .eng_go(eng_go), .eng_op(eng_op), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .done(done), .status(status)
);

// File: tb/i2c_txn_seq_tb.sv
module i2c_txn_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_chip = '0;
  logic        req_read = 1'b0;
  logic        req_probe = 1'b0;
  logic [2:0]  req_alen = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        bus_busy = 1'b0;
  logic        eng_go;
  logic [2:0]  eng_op;
  logic [7:0]  eng_byte;
  logic        eng_ack;
  logic        eng_done = 1'b0;
  logic        eng_nack = 1'b0;
  logic [7:0]  eng_rdata = '0;
  logic        wr_valid = 1'b1;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        done;
  logic [3:0]  status;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_txn_seq #(
    .ADDR_BYTES(4), .LEN_W(16), .CLK_FREQ_HZ(1_000_000),
    .TIMEOUT_US(TO_CYC), .OVF_MASK(7'h03)
  ) u_dut (.*);

  int errs = 0, checks = 0;

  // Engine and stream model, all driven at the falling edge.
  int   log_op[64], log_val[64], n_ops = 0;
  int   rd_log[64], n_rd = 0;
  logic [7:0] wbuf[8];
  int   widx = 0, rcnt = 0;
  int   nack_at = -1;
  bit   hang = 0;
  bit   pend = 0;
  int   pw = 0;
  logic p_nack;
  logic [7:0] p_rdata;

  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (pend) begin
        pw--;
        if (pw == 0) begin
          pend = 0; eng_done = 1'b1; eng_nack = p_nack; eng_rdata = p_rdata;
        end
      end
      if (eng_go) begin
        if (n_ops < 64) begin
          log_op[n_ops]  = int'(eng_op);
          log_val[n_ops] = (eng_op == 3'd3) ? int'(eng_ack) : int'(eng_byte);
        end
        if (eng_op != 3'd4 && !hang) begin
          pend = 1; pw = 2;
          p_nack = (nack_at == n_ops) || (eng_op == 3'd3 && !eng_ack);
          p_rdata = 8'hA0 + 8'(rcnt);
          if (eng_op == 3'd3) rcnt++;
        end
        n_ops++;
      end
      if (wr_ready) begin
        widx++;
        wr_data = wbuf[widx % 8];
      end
      if (rd_valid && rd_ready) begin
        if (n_rd < 64) rd_log[n_rd] = int'(rd_data);
        n_rd++;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_op(input string tag, input int i, input int op, input int val);
    check({tag, " op"}, log_op[i], op);
    if (op != 4) check({tag, " value"}, log_val[i], val);
  endtask

  task automatic run_req(input logic [6:0] chip, input logic rd, input logic probe,
                         input logic [2:0] alen, input logic [31:0] addr,
                         input logic [15:0] len, output logic [3:0] st, output int cyc);
    n_ops = 0; n_rd = 0; rcnt = 0; widx = 0; wr_data = wbuf[0];
    @(negedge clk);
    req_chip = chip; req_read = rd; req_probe = probe;
    req_alen = alen; req_addr = addr; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check("watchdog: done never rose", 0, 1);
    st = status;
  endtask

  logic [3:0] st;
  int cyc;

  task automatic t_reset();
    check("R12 reset status", int'(status), 0);
    check("R12 reset done", int'(done), 0);
    check("R1 reset no strobe", int'(eng_go), 0);
    check("R1 reset ready", int'(req_ready), 1);
  endtask

  task automatic t_write_reg();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    run_req(7'h50, 0, 0, 3'd2, 32'h1234, 16'd3, st, cyc);
    check("R12 write status OK", int'(st), 1);
    check("R2 write op count", n_ops, 7);
    exp_op("R1 write addr", 0, 0, 'hA0);
    exp_op("R2 reg msb", 1, 2, 'h12);
    exp_op("R2 reg lsb", 2, 2, 'h34);
    exp_op("R13 data0", 3, 2, 'h11);
    exp_op("R13 data1", 4, 2, 'h22);
    exp_op("R13 data2", 5, 2, 'h33);
    exp_op("R9 stop", 6, 4, 0);
    repeat (3) @(negedge clk);
    check("R12 status held", int'(status), 1);
  endtask

  task automatic t_read_reg();
    run_req(7'h50, 1, 0, 3'd1, 32'h07, 16'd3, st, cyc);
    check("R4 read status OK", int'(st), 1);
    check("R3 read op count", n_ops, 7);
    exp_op("R1 read first tx", 0, 0, 'hA0);
    exp_op("R2 read reg", 1, 2, 'h07);
    exp_op("R3 restart", 2, 1, 'hA1);
    exp_op("R4 ack0", 3, 3, 1);
    exp_op("R4 ack1", 4, 3, 1);
    exp_op("R4 final nack", 5, 3, 0);
    exp_op("R9 read stop", 6, 4, 0);
    check("R4 read count", n_rd, 3);
    check("R4 rd0", rd_log[0], 'hA0);
    check("R4 rd1", rd_log[1], 'hA1);
    check("R4 rd2", rd_log[2], 'hA2);
  endtask

  task automatic t_read_noreg();
    run_req(7'h50, 1, 0, 3'd0, 32'h0, 16'd2, st, cyc);
    check("R1 plain read status", int'(st), 1);
    check("R3 no restart count", n_ops, 4);
    exp_op("R1 plain read rx", 0, 1, 'hA1);
    exp_op("R4 plain ack", 1, 3, 1);
    exp_op("R4 plain last", 2, 3, 0);
  endtask

  task automatic t_write_noreg();
    wbuf[0] = 8'h5A;
    run_req(7'h50, 0, 0, 3'd0, 32'h0, 16'd1, st, cyc);
    check("R2 no reg op count", n_ops, 3);
    exp_op("R1 write tx", 0, 0, 'hA0);
    exp_op("R13 single byte", 1, 2, 'h5A);
    check("R12 single status", int'(st), 1);
  endtask

  task automatic t_nack_addr();
    nack_at = 0;
    run_req(7'h50, 0, 0, 3'd1, 32'h10, 16'd2, st, cyc);
    nack_at = -1;
    check("R5 addr nack status", int'(st), 2);
    check("R5 addr nack ops", n_ops, 2);
    exp_op("R9 addr nack stop", 1, 4, 0);
  endtask

  task automatic t_nack_data();
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    nack_at = 3;
    run_req(7'h50, 0, 0, 3'd1, 32'h10, 16'd3, st, cyc);
    nack_at = -1;
    check("R5 data nack status", int'(st), 2);
    check("R5 data nack ops", n_ops, 5);
    exp_op("R5 data nack stop", 4, 4, 0);
    check("R13 bytes consumed", widx, 2);
  endtask

  task automatic t_bad();
    run_req(7'h50, 0, 0, 3'd1, 32'h0, 16'd0, st, cyc);
    check("R6 zero len status", int'(st), 8);
    check("R6 zero len latency", cyc, 1);
    check("R6 zero len no ops", n_ops, 0);
    run_req(7'h50, 1, 0, 3'd5, 32'h0, 16'd2, st, cyc);
    check("R6 long alen status", int'(st), 8);
    check("R6 long alen no ops", n_ops, 0);
  endtask

  task automatic t_bus_timeout();
    bus_busy = 1'b1;
    run_req(7'h50, 0, 0, 3'd0, 32'h0, 16'd1, st, cyc);
    bus_busy = 1'b0;
    check("R7 busy timeout status", int'(st), 4);
    check("R7 busy no ops", n_ops, 0);
    check("R7 busy waited", int'(cyc >= TO_CYC && cyc <= TO_CYC + 5), 1);
  endtask

  task automatic t_bus_wait();
    bus_busy = 1'b1;
    wbuf[0] = 8'h77;
    fork
      begin repeat (20) @(negedge clk); bus_busy = 1'b0; end
    join_none
    run_req(7'h50, 0, 0, 3'd0, 32'h0, 16'd1, st, cyc);
    check("R7 bus wait then OK", int'(st), 1);
    check("R7 bus wait ops", n_ops, 3);
  endtask

  task automatic t_byte_timeout();
    hang = 1;
    run_req(7'h50, 0, 0, 3'd0, 32'h0, 16'd1, st, cyc);
    hang = 0; pend = 0;
    check("R8 byte timeout status", int'(st), 4);
    check("R8 byte timeout ops", n_ops, 2);
    exp_op("R8 timeout stop", 1, 4, 0);
  endtask

  task automatic t_overflow();
    wbuf[0] = 8'hEE;
    run_req(7'h50, 0, 0, 3'd1, 32'h0305, 16'd1, st, cyc);
    exp_op("R10 folded chip", 0, 0, 'hA6);
    exp_op("R10 low reg byte", 1, 2, 'h05);
  endtask

  task automatic t_wide_addr();
    wbuf[0] = 8'h42;
    run_req(7'h21, 0, 0, 3'd4, 32'hDEADBEEF, 16'd1, st, cyc);
    exp_op("R10 wide no fold", 0, 0, 'h42);
    exp_op("R2 b3", 1, 2, 'hDE);
    exp_op("R2 b2", 2, 2, 'hAD);
    exp_op("R2 b1", 3, 2, 'hBE);
    exp_op("R2 b0", 4, 2, 'hEF);
    check("R2 wide status", int'(st), 1);
  endtask

  task automatic t_probe();
    run_req(7'h22, 0, 1, 3'd3, 32'h0, 16'd0, st, cyc);
    check("R11 probe status", int'(st), 1);
    check("R11 probe ops", n_ops, 3);
    exp_op("R11 probe addr", 0, 1, 'h45);
    exp_op("R11 probe nack", 1, 3, 0);
    check("R11 probe no data", n_rd, 0);
    nack_at = 0;
    run_req(7'h22, 0, 1, 3'd0, 32'h0, 16'd1, st, cyc);
    nack_at = -1;
    check("R11 absent probe", int'(st), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_reg();
    t_read_reg();
    t_read_noreg();
    t_write_noreg();
    t_nack_addr();
    t_nack_data();
    t_bad();
    t_bus_timeout();
    t_bus_wait();
    t_byte_timeout();
    t_overflow();
    t_wide_addr();
    t_probe();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule